// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Burst SRAM

This block is a synthesizable model of a synchronous static RAM whose data bus can change direction on any cycle. Reads and writes may alternate on every clock without idle cycles. Every access is registered at the rising clock edge. Write data follows its address by the same two enabled edges that read data takes to appear, so the bus timing is the same in both directions. A small on-chip array, sized by parameter, stands in for the memory core. The data bus is split into separate input and output ports, with an output-enable flag that marks the cycles in which the block would drive the bus.

Each access either loads a new address or advances a 2-bit burst counter over the four words of an aligned group. The order of the four words is interleaved or linear. A three-input select decides whether a loaded access is a real cycle or a deselect. A global freeze input suspends the whole pipeline. A read that hits a word whose write has been accepted but not yet committed to the array returns the newer bytes, lane by lane.

Top module: `ntb_sram`

## Requirements
- R1: Read data for a read beat appears on `dout`, with `dout_en` high, after the second enabled rising edge that follows the edge that registered the beat's address.
- R2: For a write beat, `din` is sampled at the second enabled edge after the address edge. Lane k (bits 9k+8..9k) of the word is written only if `lane_en[k]` was high at the address edge of that beat.
- R3: Reads and writes can alternate on consecutive enabled edges with no idle cycle. A read always returns the latest data written to its word by every write beat whose address was registered before the read's address, merged per lane.
- R4: While `freeze` is high, an edge ignores every input except `rst`, and `dout`, `dout_en` and all pipeline state keep their values.
- R5: With `step` low, a beat is a real access only when `sel_a`=1, `sel_b_n`=0 and `sel_c_n`=0. It is then a read if `rd_wr`=1 and a write if `rd_wr`=0. Any other select combination makes a deselect beat, which neither writes nor raises `dout_en`.
- R6: With `step` high, the select and `rd_wr` inputs are ignored. The beat keeps the access type of the current burst, the 2-bit count increments (wrapping 3 to 0), and address bits above bit 1 stay those of the loaded address.
- R7: If `order_lin` was 0 at the load, the beat's low two address bits equal the loaded low bits XOR the count.
- R8: If `order_lin` was 1 at the load, the beat's low two address bits equal the loaded low bits plus the count, modulo 4.
- R9: `dout_en` is high only in the cycle that carries valid read data. It is low in write-data cycles and in cycles that belong to deselect beats.
- R10: Reset is synchronous and active high. It clears `dout` and `dout_en` and turns every beat in the pipeline into a deselect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| freeze | input | 1 | High: the edge is ignored and all state holds |
| step | input | 1 | Low: load a new address. High: advance the burst |
| rd_wr | input | 1 | At a load: 1 read, 0 write |
| sel_a | input | 1 | Select, active high |
| sel_b_n | input | 1 | Select, active low |
| sel_c_n | input | 1 | Select, active low |
| order_lin | input | 1 | At a load: 1 linear, 0 interleaved burst order |
| addr | input | AW | Word address |
| lane_en | input | LANES | Per-lane write enables for this beat |
| din | input | LANES*LW | Write data, two enabled edges after its address |
| dout | output | LANES*LW | Registered read data |
| dout_en | output | 1 | High when `dout` carries read data |

## Verification
If the burst counter or the latched order bit is wrong, the very next read beat returns a neighbouring word of its group. This shows at `dout` exactly two enabled edges after that beat's address. If the write-forwarding state is stale or missing, a read placed directly behind a write to the same word returns old bytes in the enabled lanes, again within two edges. If a stage's access type is lost or kept through a freeze, `dout_en` is wrong in the very cycle that stage reaches the output. Because the reference model is compared on every clock, each such fault appears within two enabled edges of the beat that caused it.

// File: rtl/ntb_sram_pkg.sv
package ntb_sram_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // low address bits of a burst beat
  function automatic logic [1:0] beat_low(input logic [1:0] base,
                                          input logic [1:0] cnt,
                                          input logic       lin);
    return lin ? (base + cnt) : (base ^ cnt);
  endfunction

endpackage

// File: rtl/ntb_sram_seq.sv
module ntb_sram_seq
  import ntb_sram_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             step,
  input  logic             rd_wr,
  input  logic             sel_ok,
  input  logic             order_lin,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] lane_en,
  output op_e              beat_op,
  output logic [AW-1:0]    beat_addr,
  output logic [LANES-1:0] beat_mask
);

  logic [AW-1:0]    base_q;
  logic [1:0]       cnt_q;
  logic             lin_q;
  op_e              op_q;
  logic [LANES-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
      lin_q  <= 1'b0;
      op_q   <= OP_NONE;
      mask_q <= '0;
    end else if (en) begin
      mask_q <= lane_en;
      if (!step) begin
        base_q <= addr;
        cnt_q  <= '0;
        lin_q  <= order_lin;
        op_q   <= !sel_ok ? OP_NONE : (rd_wr ? OP_RD : OP_WR);
      end else begin
        cnt_q  <= cnt_q + 2'd1;
      end
    end
  end

  assign beat_op   = op_q;
  assign beat_addr = {base_q[AW-1:2], beat_low(base_q[1:0], cnt_q, lin_q)};
  assign beat_mask = mask_q;

endmodule

// File: rtl/ntb_sram_core.sv
module ntb_sram_core #(
  parameter int AW    = 8,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                  clk,
  input  logic                  rd_en,
  input  logic [AW-1:0]         rd_addr,
  output logic [LANES*LW-1:0]   rd_data,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [LANES-1:0]      wr_mask,
  input  logic [LANES*LW-1:0]   wr_data
);

  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // synchronous read-before-write array, lane write enables
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
    if (wr_en) begin
      for (int g = 0; g < LANES; g++) begin
        if (wr_mask[g]) mem[wr_addr][g*LW +: LW] <= wr_data[g*LW +: LW];
      end
    end
  end

endmodule

// File: rtl/ntb_sram_out.sv
module ntb_sram_out
  import ntb_sram_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  op_e                 op2,
  input  logic [AW-1:0]       addr2,
  input  logic [LANES-1:0]    mask2,
  input  logic [LANES*LW-1:0] din,
  input  logic [LANES*LW-1:0] rd_data,
  output logic [LANES*LW-1:0] dout,
  output logic                dout_en
);

  localparam int DW = LANES * LW;

  logic             fwd_v;
  logic [AW-1:0]    fwd_addr;
  logic [LANES-1:0] fwd_mask;
  logic [DW-1:0]    fwd_data;
  logic [DW-1:0]    merged;

  // the write committed on the previous edge is invisible to the array read
  always_comb begin
    for (int g = 0; g < LANES; g++) begin
      merged[g*LW +: LW] = (fwd_v && fwd_addr == addr2 && fwd_mask[g])
                           ? fwd_data[g*LW +: LW] : rd_data[g*LW +: LW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_v    <= 1'b0;
      fwd_addr <= '0;
      fwd_mask <= '0;
      fwd_data <= '0;
      dout     <= '0;
      dout_en  <= 1'b0;
    end else if (en) begin
      fwd_v    <= (op2 == OP_WR);
      fwd_addr <= addr2;
      fwd_mask <= mask2;
      fwd_data <= din;
      dout_en  <= (op2 == OP_RD);
      if (op2 == OP_RD) dout <= merged;
    end
  end

endmodule

// File: rtl/ntb_sram.sv
module ntb_sram
  import ntb_sram_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4,
  parameter int LW    = 9,
  localparam int DW   = LANES * LW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             freeze,
  input  logic             step,
  input  logic             rd_wr,
  input  logic             sel_a,
  input  logic             sel_b_n,
  input  logic             sel_c_n,
  input  logic             order_lin,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] lane_en,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic             dout_en
);

  logic             en;
  logic             sel_ok;
  op_e              s1_op;
  logic [AW-1:0]    s1_addr;
  logic [LANES-1:0] s1_mask;
  op_e              op2;
  logic [AW-1:0]    addr2;
  logic [LANES-1:0] mask2;
  logic [DW-1:0]    rd_data;

  assign en     = !freeze;
  assign sel_ok = sel_a && !sel_b_n && !sel_c_n;

  ntb_sram_seq #(.AW(AW), .LANES(LANES)) seq_i (
    .clk(clk), .rst(rst), .en(en), .step(step), .rd_wr(rd_wr),
    .sel_ok(sel_ok), .order_lin(order_lin), .addr(addr), .lane_en(lane_en),
    .beat_op(s1_op), .beat_addr(s1_addr), .beat_mask(s1_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op2   <= OP_NONE;
      addr2 <= '0;
      mask2 <= '0;
    end else if (en) begin
      op2   <= s1_op;
      addr2 <= s1_addr;
      mask2 <= s1_mask;
    end
  end

  ntb_sram_core #(.AW(AW), .LANES(LANES), .LW(LW)) core_i (
    .clk(clk),
    .rd_en(en && s1_op == OP_RD), .rd_addr(s1_addr), .rd_data(rd_data),
    .wr_en(en && op2 == OP_WR), .wr_addr(addr2), .wr_mask(mask2), .wr_data(din)
  );

  ntb_sram_out #(.AW(AW), .LANES(LANES), .LW(LW)) out_i (
    .clk(clk), .rst(rst), .en(en), .op2(op2), .addr2(addr2), .mask2(mask2),
    .din(din), .rd_data(rd_data), .dout(dout), .dout_en(dout_en)
  );

endmodule

// File: rtl/ntb_sram_chk.sv
module ntb_sram_chk
  import ntb_sram_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst,
  input logic          freeze,
  input logic          step,
  input logic          sel_a,
  input logic          sel_b_n,
  input logic          sel_c_n,
  input op_e           s1_op,
  input logic [AW-1:0] s1_addr,
  input op_e           op2,
  input logic [DW-1:0] dout,
  input logic          dout_en
);

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (!dout_en && dout == '0));

  p_freeze_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (freeze && !rst) |=> ($stable(dout) && $stable(dout_en) &&
                          $stable(s1_op) && $stable(s1_addr)));

  p_deselect_load_r5: assert property (@(posedge clk) disable iff (rst)
    (!freeze && !step && !(sel_a && !sel_b_n && !sel_c_n)) |=> (s1_op == OP_NONE));

  p_burst_continue_r6: assert property (@(posedge clk) disable iff (rst)
    (!freeze && step) |=> (s1_op == $past(s1_op) &&
                           s1_addr[AW-1:2] == $past(s1_addr[AW-1:2])));

  p_read_drives_r1: assert property (@(posedge clk) disable iff (rst)
    (!freeze && op2 == OP_RD) |=> dout_en);

  p_quiet_otherwise_r9: assert property (@(posedge clk) disable iff (rst)
    (!freeze && op2 != OP_RD) |=> !dout_en);

endmodule

bind ntb_sram ntb_sram_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst(rst), .freeze(freeze), .step(step),
  .sel_a(sel_a), .sel_b_n(sel_b_n), .sel_c_n(sel_c_n),
  .s1_op(s1_op), .s1_addr(s1_addr), .op2(op2),
  .dout(dout), .dout_en(dout_en)
);

// File: tb/ntb_sram_tb_top.sv
module ntb_sram_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 8;
  localparam int LANES = 4;
  localparam int LW    = 9;
  localparam int DW    = LANES * LW;
  localparam bit [2:0] SEL_ON = 3'b100;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             freeze = 1'b0;
  logic             step = 1'b0;
  logic             rd_wr = 1'b1;
  logic             sel_a = 1'b0;
  logic             sel_b_n = 1'b1;
  logic             sel_c_n = 1'b1;
  logic             order_lin = 1'b0;
  logic [AW-1:0]    addr = '0;
  logic [LANES-1:0] lane_en = '0;
  logic [DW-1:0]    din = '0;
  logic [DW-1:0]    dout;
  logic             dout_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  ntb_sram #(.AW(AW), .LANES(LANES), .LW(LW)) dut_i (
    .clk(clk), .rst(rst), .freeze(freeze), .step(step), .rd_wr(rd_wr),
    .sel_a(sel_a), .sel_b_n(sel_b_n), .sel_c_n(sel_c_n), .order_lin(order_lin),
    .addr(addr), .lane_en(lane_en), .din(din), .dout(dout), .dout_en(dout_en)
  );

  // ---------------- behavioural reference ----------------
  typedef struct {
    int               op;   // 0 none, 1 read, 2 write
    int               wa;
    logic [LANES-1:0] mask;
  } item_t;

  item_t         pipe[$];
  item_t         old_it;
  item_t         new_it;
  logic [DW-1:0] mref [int];
  int            m_op, m_base, m_cnt, m_low;
  bit            m_lin;
  logic          exp_en = 1'b0;
  logic [DW-1:0] exp_dout = '0;

  always @(posedge clk) begin
    if (rst) begin
      pipe.delete();
      new_it.op = 0; new_it.wa = 0; new_it.mask = '0;
      pipe.push_back(new_it);
      pipe.push_back(new_it);
      exp_en = 1'b0; exp_dout = '0;
      m_op = 0; m_base = 0; m_cnt = 0; m_lin = 1'b0;
    end else if (!freeze) begin
      old_it = pipe.pop_front();
      exp_en = (old_it.op == 1);
      if (old_it.op == 2) begin
        for (int k = 0; k < LANES; k++)
          if (old_it.mask[k]) mref[old_it.wa][k*LW +: LW] = din[k*LW +: LW];
      end
      if (old_it.op == 1) exp_dout = mref[old_it.wa];
      if (!step) begin
        m_base = int'(addr); m_cnt = 0; m_lin = order_lin;
        m_op = (sel_a && !sel_b_n && !sel_c_n) ? (rd_wr ? 1 : 2) : 0;
      end else begin
        m_cnt = (m_cnt + 1) % 4;
      end
      m_low = m_lin ? ((m_base + m_cnt) % 4) : ((m_base % 4) ^ m_cnt);
      new_it.op = m_op;
      new_it.wa = (m_base / 4) * 4 + m_low;
      new_it.mask = lane_en;
      pipe.push_back(new_it);
    end
  end

  // ---------------- checking ----------------
  int    nchk = 0;
  int    nfail = 0;
  bit    started = 1'b0;
  bit    done = 1'b0;
  string phase = "R10 reset";

  task automatic check(input bit ok, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s act=%h exp=%h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      check(dout_en === exp_en, "R9 dout_en", DW'(dout_en), DW'(exp_en));
      if (exp_en) check(dout === exp_dout, "R1 dout", dout, exp_dout);
    end
  end

  task automatic cyc(input bit stp, input bit rw, input bit [2:0] sel,
                     input int a, input logic [LANES-1:0] m,
                     input bit lin, input bit frz);
    logic [63:0] r;
    @(negedge clk);
    r = {$urandom(), $urandom()};
    step = stp; rd_wr = rw; {sel_a, sel_b_n, sel_c_n} = sel;
    addr = AW'(a); lane_en = m; order_lin = lin; freeze = frz;
    din = r[DW-1:0];
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 1, 3'b000, 0, '0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    phase = "R10 reset";
    check(dout_en === 1'b0, "R10 dout_en after reset", DW'(dout_en), '0);
    check(dout === '0, "R10 dout after reset", dout, '0);
    @(negedge clk);
    rst = 1'b0;
    started = 1'b1;

    phase = "R2 fill";
    for (int a = 0; a < 16; a++) cyc(0, 0, SEL_ON, a, '1, 0, 0);
    idle(2);

    phase = "R1 readback";
    for (int a = 0; a < 16; a++) cyc(0, 1, SEL_ON, a, '0, 0, 0);
    idle(2);

    phase = "R2 lanes";
    for (int a = 0; a < 16; a++) cyc(0, 0, SEL_ON, a, LANES'(a), 0, 0);
    for (int a = 0; a < 16; a++) cyc(0, 1, SEL_ON, a, '0, 0, 0);
    idle(2);

    phase = "R3 alternate";
    for (int i = 0; i < 300; i++) begin
      int a;
      a = int'($urandom % 16);
      cyc(0, 0, SEL_ON, a, LANES'($urandom), 0, 0);
      cyc(0, 1, SEL_ON, (i % 3 == 0) ? int'($urandom % 16) : a, '0, 0, 0);
    end
    idle(2);

    phase = "R7 interleaved";
    for (int b = 0; b < 16; b++) begin
      cyc(0, b % 2, SEL_ON, b, LANES'($urandom), 0, 0);
      for (int s = 0; s < 5; s++) cyc(1, 0, 3'b000, 0, LANES'($urandom), 1, 0);
    end
    idle(2);

    phase = "R8 linear";
    for (int b = 0; b < 16; b++) begin
      cyc(0, b % 2, SEL_ON, b, LANES'($urandom), 1, 0);
      for (int s = 0; s < 5; s++) cyc(1, 1, 3'b000, 0, LANES'($urandom), 0, 0);
    end
    idle(2);

    phase = "R6 burst keeps type";
    for (int i = 0; i < 40; i++) begin
      cyc(0, $urandom % 2, (i % 2) ? SEL_ON : 3'b011, int'($urandom % 16), '1, $urandom % 2, 0);
      for (int s = 0; s < 3; s++) cyc(1, $urandom % 2, SEL_ON, 0, LANES'($urandom), 0, 0);
    end
    idle(2);

    phase = "R5 select";
    for (int c = 0; c < 8; c++) begin
      cyc(0, c % 2, 3'(c), int'($urandom % 16), '1, 0, 0);
      cyc(0, 1, SEL_ON, int'($urandom % 16), '0, 0, 0);
    end
    idle(2);

    phase = "R4 freeze";
    for (int i = 0; i < 600; i++)
      cyc($urandom % 3 == 0, $urandom % 2, ($urandom % 5 == 0) ? 3'(~$urandom % 8) : SEL_ON,
          int'($urandom % 16), LANES'($urandom), $urandom % 2, $urandom % 10 < 3);
    cyc(0, 1, 3'b000, 0, '0, 0, 0);
    idle(2);

    phase = "R9 mixed";
    for (int i = 0; i < 1500; i++)
      cyc($urandom % 2, $urandom % 2, ($urandom % 6 == 0) ? 3'(~$urandom % 8) : SEL_ON,
          int'($urandom % 16), LANES'($urandom), $urandom % 2, $urandom % 12 == 0);
    cyc(0, 1, 3'b000, 0, '0, 0, 0);
    idle(4);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL R1 watchdog act=%0d exp=%0d", 0, 1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

endmodule